// File: doc/BRIEF.md
# Bidirectional Systolic Attention Grid

This block is a square, input-stationary grid of multiply-accumulate elements that runs both matrix products of one attention tile in a single pass. Before a tile starts, each element holds two stationary 8-bit operands: one key element and one value element. Query rows are then fed in from the left edge. Partial sums travel upward, so query-key scores leave the top edge one column per cycle. Each score that leaves the top of column p goes through a saturating exponent stub and becomes a weight. That weight enters row p of the grid from the left. The weighted-value sums then travel downward and leave the bottom edge. A running-maximum stub watches the scores as they leave the top edge and reports the maximum of each score row.

The timing is fixed. Element (p, c) follows a diagonal wavefront set by its row index, its column index and one global cycle counter. The downward pass starts in the top-left element as soon as the first score is available, and the score phase of later rows is still running at that point. A start pulse launches one tile. A done pulse marks the cycle in which the last result appears. There are no stalls that depend on the data.

Top module: `bidir_systolic_grid`

## Requirements
- R1: After reset, score_o, out_o and rowmax_o are zero, and every valid flag, busy_o and done_o are low.
- R2: While ld_en_i is high, ld_sel_i selects the target of the write. 0 writes key element K[ld_row_i][ld_col_i], where the row is the key index and the column is the feature index. 1 writes value element V[ld_row_i][ld_col_i], where the row is the feature index and the column is the output column. 2 writes query element Q[ld_row_i][ld_col_i]. A write made while busy_o is high has no effect.
- R3: Cycle t=0 is the cycle after the clock edge that samples start_i high. In cycle i+c+N, score_vld_o[c] is high and score field c (bits c*ACC_W upward) carries S[i][c] = sum over k of Q[i][k]*K[c][k]. Outside those cycles the field is zero and its flag is low.
- R4: The weight is W[i][k] = S[i][k] shifted right arithmetically by W_SHIFT and then saturated to the range -128..127.
- R5: In cycle i+c+2N, out_vld_o[c] is high and out field c carries O[i][c] = sum over k of W[i][k]*V[k][c], summed for k in ascending order. Otherwise the field is zero and its flag is low. The top-left element therefore starts its downward work in cycle N, while scores are still leaving the grid.
- R6: In cycle i+2N, rowmax_vld_o is high and rowmax_o equals the maximum of S[i][0..N-1].
- R7: busy_o is high in cycles 0 through 4N-2. done_o is a single pulse in cycle 4N-2, and the block is idle afterwards.
- R8: A start_i pulse that arrives while busy_o is high is ignored. It does not restart or extend the tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_en_i | input | 1 | Operand write enable |
| ld_sel_i | input | 2 | Write target: 0 key, 1 value, 2 query |
| ld_row_i | input | $clog2(N) | Row index of the write |
| ld_col_i | input | $clog2(N) | Column index of the write |
| ld_data_i | input | DATA_W | Signed operand value |
| start_i | input | 1 | Launches one tile |
| score_o | output | N*ACC_W | Top-edge scores, one signed field per column |
| score_vld_o | output | N | Valid flag for each score field |
| rowmax_o | output | ACC_W | Maximum of one score row |
| rowmax_vld_o | output | 1 | rowmax_o is valid |
| out_o | output | N*ACC_W | Bottom-edge weighted-value sums, one field per column |
| out_vld_o | output | N | Valid flag for each output field |
| busy_o | output | 1 | A tile is in progress |
| done_o | output | 1 | The last result is present in this cycle |

## Verification
Random tiles over the full 8-bit range drive the weight stub mostly into saturation. Tiles with small values keep the weights in the linear part of the stub, so the two cases separate an error in the shift from an error in the clamp. An identity key tile makes each score equal to its query element, which exposes any column or row swap in the key mapping. Uniform extreme tiles hit the positive and negative saturation limits and the largest accumulator values. A tile that writes operands and pulses start in the middle of its own run, followed by a rerun without reloading, separates ignored writes and starts from ones that take effect.

// File: rtl/bsg_pkg.sv
package bsg_pkg;
  typedef enum logic [1:0] {
    LD_KEY = 2'd0,
    LD_VAL = 2'd1,
    LD_QRY = 2'd2
  } ld_sel_e;
endpackage

// File: rtl/bsg_pe.sv
module bsg_pe #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 24
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     busy_i,
  input  logic                     ld_k_i,
  input  logic                     ld_v_i,
  input  logic signed [DATA_W-1:0] ld_data_i,
  input  logic signed [DATA_W-1:0] q_i,
  output logic signed [DATA_W-1:0] q_o,
  input  logic signed [ACC_W-1:0]  psu_i,
  output logic signed [ACC_W-1:0]  psu_o,
  input  logic signed [DATA_W-1:0] w_i,
  output logic signed [DATA_W-1:0] w_o,
  input  logic signed [ACC_W-1:0]  psd_i,
  output logic signed [ACC_W-1:0]  psd_o
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int EXT_W  = ACC_W - PROD_W;

  logic signed [DATA_W-1:0] k_q, v_q;
  logic signed [PROD_W-1:0] up_prod, dn_prod;
  logic signed [ACC_W-1:0]  up_ext, dn_ext;

  assign up_prod = q_i * k_q;
  assign dn_prod = w_i * v_q;
  assign up_ext  = {{EXT_W{up_prod[PROD_W-1]}}, up_prod};
  assign dn_ext  = {{EXT_W{dn_prod[PROD_W-1]}}, dn_prod};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_q   <= '0;
      v_q   <= '0;
      q_o   <= '0;
      w_o   <= '0;
      psu_o <= '0;
      psd_o <= '0;
    end else begin
      if (ld_k_i) k_q <= ld_data_i;
      if (ld_v_i) v_q <= ld_data_i;
      q_o   <= q_i;
      w_o   <= w_i;
      psu_o <= psu_i + up_ext;  // upward: score partial sum
      psd_o <= psd_i + dn_ext;  // downward: weighted-value partial sum
    end
  end

  p_stationary_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(k_q) && $stable(v_q)));
endmodule

// File: rtl/bsg_seq.sv
module bsg_seq #(
  parameter int N     = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  localparam int LAST = 4 * N - 2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_o  <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1;
        cnt_o  <= '0;
      end
    end else if (done_o) begin
      busy_o <= 1'b0;
    end else begin
      cnt_o <= cnt_o + CNT_W'(1);
    end
  end

  assign done_o = busy_o && (cnt_o == CNT_W'(LAST));

  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  p_start_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !done_o) |=> (busy_o && cnt_o == $past(cnt_o) + CNT_W'(1)));
endmodule

// File: rtl/bsg_exp_stub.sv
module bsg_exp_stub #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 24,
  parameter int SHIFT  = 4
) (
  input  logic signed [ACC_W-1:0]  s_i,
  output logic signed [DATA_W-1:0] w_o
);
  localparam int W_MAX = (1 << (DATA_W - 1)) - 1;
  localparam int W_MIN = -(1 << (DATA_W - 1));

  logic signed [ACC_W-1:0] sh;
  assign sh = s_i >>> SHIFT;

  always_comb begin
    if (sh > $signed(ACC_W'(W_MAX)))      w_o = DATA_W'(W_MAX);
    else if (sh < $signed(ACC_W'(W_MIN))) w_o = DATA_W'(W_MIN);
    else                                  w_o = sh[DATA_W-1:0];
  end
endmodule

// File: rtl/bsg_max_chain.sv
module bsg_max_chain #(
  parameter int N     = 4,
  parameter int ACC_W = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N*ACC_W-1:0]      s_i,
  output logic signed [ACC_W-1:0] max_o
);
  logic signed [ACC_W-1:0] cur [N];
  logic signed [ACC_W-1:0] m_q [N];

  always_comb
    for (int c = 0; c < N; c++) cur[c] = s_i[c*ACC_W +: ACC_W];

  // diagonal chain: stage c sees column c of the same score row
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < N; c++) m_q[c] <= '0;
    end else begin
      m_q[0] <= cur[0];
      for (int c = 1; c < N; c++) m_q[c] <= (cur[c] > m_q[c-1]) ? cur[c] : m_q[c-1];
    end
  end

  assign max_o = m_q[N-1];
endmodule

// File: rtl/bidir_systolic_grid.sv
module bidir_systolic_grid
  import bsg_pkg::*;
#(
  parameter int N       = 4,
  parameter int DATA_W  = 8,
  parameter int ACC_W   = 24,
  parameter int W_SHIFT = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ld_en_i,
  input  logic [1:0]                ld_sel_i,
  input  logic [$clog2(N)-1:0]      ld_row_i,
  input  logic [$clog2(N)-1:0]      ld_col_i,
  input  logic [DATA_W-1:0]         ld_data_i,
  input  logic                      start_i,
  output logic [N*ACC_W-1:0]        score_o,
  output logic [N-1:0]              score_vld_o,
  output logic [ACC_W-1:0]          rowmax_o,
  output logic                      rowmax_vld_o,
  output logic [N*ACC_W-1:0]        out_o,
  output logic [N-1:0]              out_vld_o,
  output logic                      busy_o,
  output logic                      done_o
);
  localparam int IDX_W = $clog2(N);
  localparam int CNT_W = $clog2(4 * N);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  ld_sel_e          sel;
  logic             wr_ok;

  logic signed [DATA_W-1:0] qbuf   [N][N];
  logic signed [DATA_W-1:0] q_edge [N];
  logic signed [DATA_W-1:0] qh     [N][N+1];
  logic signed [DATA_W-1:0] wh     [N][N+1];
  logic signed [ACC_W-1:0]  psu    [N+1][N];
  logic signed [ACC_W-1:0]  psd    [N+1][N];

  assign sel   = ld_sel_e'(ld_sel_i);
  assign wr_ok = ld_en_i && !busy;

  bsg_seq #(.N(N), .CNT_W(CNT_W)) seq_i (
    .clk_i, .rst_ni, .start_i,
    .busy_o(busy), .cnt_o(cnt), .done_o
  );
  assign busy_o = busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) qbuf[r][c] <= '0;
    end else if (wr_ok && sel == LD_QRY) begin
      qbuf[ld_row_i][ld_col_i] <= ld_data_i;
    end
  end

  // row p carries feature u = N-1-p; query row i enters at cycle i+u
  always_comb begin
    for (int p = 0; p < N; p++) begin
      automatic int u = N - 1 - p;
      automatic int i = int'(cnt) - u;
      q_edge[p] = '0;
      if (busy && i >= 0 && i < N) q_edge[p] = qbuf[i[IDX_W-1:0]][u];
    end
  end

  always_comb begin
    for (int c = 0; c < N; c++) begin
      score_vld_o[c] = busy && int'(cnt) >= c + N     && int'(cnt) < c + 2 * N;
      out_vld_o[c]   = busy && int'(cnt) >= c + 2 * N && int'(cnt) < c + 3 * N;
    end
    rowmax_vld_o = busy && int'(cnt) >= 2 * N && int'(cnt) < 3 * N;
  end

  for (genvar p = 0; p < N; p++) begin : g_row
    assign qh[p][0] = q_edge[p];

    bsg_exp_stub #(.DATA_W(DATA_W), .ACC_W(ACC_W), .SHIFT(W_SHIFT)) exp_i (
      .s_i(psu[0][p]), .w_o(wh[p][0])
    );

    for (genvar c = 0; c < N; c++) begin : g_col
      logic ld_k, ld_v;
      assign ld_k = wr_ok && sel == LD_KEY && ld_row_i == IDX_W'(c) && ld_col_i == IDX_W'(N-1-p);
      assign ld_v = wr_ok && sel == LD_VAL && ld_row_i == IDX_W'(p) && ld_col_i == IDX_W'(c);

      bsg_pe #(.DATA_W(DATA_W), .ACC_W(ACC_W)) pe_i (
        .clk_i, .rst_ni, .busy_i(busy),
        .ld_k_i(ld_k), .ld_v_i(ld_v), .ld_data_i(ld_data_i),
        .q_i(qh[p][c]),    .q_o(qh[p][c+1]),
        .psu_i(psu[p+1][c]), .psu_o(psu[p][c]),
        .w_i(wh[p][c]),    .w_o(wh[p][c+1]),
        .psd_i(psd[p][c]), .psd_o(psd[p+1][c])
      );
    end
  end

  for (genvar c = 0; c < N; c++) begin : g_edge
    assign psu[N][c] = '0;
    assign psd[0][c] = '0;
    assign score_o[c*ACC_W +: ACC_W] = psu[0][c];
    assign out_o[c*ACC_W +: ACC_W]   = psd[N][c];
  end

  bsg_max_chain #(.N(N), .ACC_W(ACC_W)) max_i (
    .clk_i, .rst_ni, .s_i(score_o), .max_o(rowmax_o)
  );

  p_rowmax_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rowmax_vld_o |-> ($signed(rowmax_o) >= $past(psu[0][N-1])));
endmodule

// File: tb/bidir_systolic_grid_tb_top.sv
module bidir_systolic_grid_tb_top;
  localparam int N = 4, DW = 8, AW = 24, SH = 4, IW = $clog2(N);
  localparam int LAST = 4 * N - 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic ld_en = 0, start = 0;
  logic [1:0] ld_sel = 0;
  logic [IW-1:0] ld_row = 0, ld_col = 0;
  logic [DW-1:0] ld_data = 0;
  logic [N*AW-1:0] score_o, out_o;
  logic [N-1:0] score_vld_o, out_vld_o;
  logic [AW-1:0] rowmax_o;
  logic rowmax_vld_o, busy_o, done_o;

  bidir_systolic_grid #(.N(N), .DATA_W(DW), .ACC_W(AW), .W_SHIFT(SH)) dut_i (
    .clk_i(clk), .rst_ni, .ld_en_i(ld_en), .ld_sel_i(ld_sel), .ld_row_i(ld_row),
    .ld_col_i(ld_col), .ld_data_i(ld_data), .start_i(start),
    .score_o, .score_vld_o, .rowmax_o, .rowmax_vld_o,
    .out_o, .out_vld_o, .busy_o, .done_o
  );

  int checks = 0, errors = 0;
  int qm[N][N], km[N][N], vm[N][N], sm[N][N], wm[N][N], om[N][N], mx[N];

  function automatic int clampw(int s);
    int x = s >>> SH;
    if (x > 127) return 127;
    if (x < -128) return -128;
    return x;
  endfunction

  task automatic model();
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        sm[i][j] = 0;
        for (int k = 0; k < N; k++) sm[i][j] += qm[i][k] * km[j][k];
        wm[i][j] = clampw(sm[i][j]);
      end
      mx[i] = sm[i][0];
      for (int j = 1; j < N; j++) if (sm[i][j] > mx[i]) mx[i] = sm[i][j];
    end
    for (int i = 0; i < N; i++)
      for (int c = 0; c < N; c++) begin
        om[i][c] = 0;
        for (int k = 0; k < N; k++) om[i][c] += wm[i][k] * vm[k][c];
      end
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ld(int sel, int r, int c, int d);
    ld_en = 1; ld_sel = 2'(sel); ld_row = IW'(r); ld_col = IW'(c); ld_data = DW'(d);
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic load_all();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        ld(0, r, c, km[r][c]);
        ld(1, r, c, vm[r][c]);
        ld(2, r, c, qm[r][c]);
      end
  endtask

  task automatic run_tile(bit disturb, string note);
    model();
    start = 1;
    @(negedge clk);
    start = 0;
    for (int t = 0; t <= LAST + 2; t++) begin
      for (int c = 0; c < N; c++) begin
        bit sv = (t >= c + N) && (t < c + 2 * N);
        bit ov = (t >= c + 2 * N) && (t < c + 3 * N);
        int sa = int'($signed(score_o[c*AW +: AW]));
        int oa = int'($signed(out_o[c*AW +: AW]));
        chk(score_vld_o[c] == sv, $sformatf("R3 score_vld c%0d t%0d %s", c, t, note), int'(score_vld_o[c]), int'(sv));
        chk(sa == (sv ? sm[t-c-N][c] : 0), $sformatf("R3 score c%0d t%0d %s", c, t, note), sa, sv ? sm[t-c-N][c] : 0);
        chk(out_vld_o[c] == ov, $sformatf("R5 out_vld c%0d t%0d %s", c, t, note), int'(out_vld_o[c]), int'(ov));
        chk(oa == (ov ? om[t-c-2*N][c] : 0), $sformatf("R4 R5 out c%0d t%0d %s", c, t, note), oa, ov ? om[t-c-2*N][c] : 0);
      end
      begin
        bit mv = (t >= 2 * N) && (t < 3 * N);
        chk(rowmax_vld_o == mv, $sformatf("R6 rowmax_vld t%0d %s", t, note), int'(rowmax_vld_o), int'(mv));
        if (mv) chk(int'($signed(rowmax_o)) == mx[t-2*N], $sformatf("R6 rowmax t%0d %s", t, note),
                    int'($signed(rowmax_o)), mx[t-2*N]);
      end
      chk(done_o == (t == LAST), $sformatf("R7 R8 done t%0d %s", t, note), int'(done_o), int'(t == LAST));
      chk(busy_o == (t <= LAST), $sformatf("R7 R8 busy t%0d %s", t, note), int'(busy_o), int'(t <= LAST));
      if (disturb) begin
        // R2: writes during busy; R8: start during busy
        ld_en = (t == 1 || t == 2);
        ld_sel = (t == 1) ? 2'd1 : 2'd2;
        ld_row = (t == 1) ? IW'(0) : IW'(N - 1);
        ld_col = '0;
        ld_data = 8'h55;
        start = (t == 3 || t == LAST);
      end
      @(negedge clk);
    end
    ld_en = 0; start = 0;
  endtask

  task automatic fill(int lo, int hi);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        qm[r][c] = int'($urandom_range(hi - lo, 0)) + lo;
        km[r][c] = int'($urandom_range(hi - lo, 0)) + lo;
        vm[r][c] = int'($urandom_range(hi - lo, 0)) + lo;
      end
  endtask

  task automatic fill_const(int qv, int kv, int vv);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        qm[r][c] = qv; km[r][c] = kv; vm[r][c] = vv;
      end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk(score_o == '0, "R1 score", 0, 0);
    chk(out_o == '0, "R1 out", 0, 0);
    chk(rowmax_o == '0, "R1 rowmax", int'(rowmax_o), 0);
    chk({score_vld_o, out_vld_o, rowmax_vld_o} == '0, "R1 valids", 0, 0);
    chk(!busy_o && !done_o, "R1 busy/done", int'({busy_o, done_o}), 0);

    fill(-128, 127);  load_all(); run_tile(0, "random_full");
    fill(-7, 7);      load_all(); run_tile(0, "small_linear");
    fill_const(-128, -128, 127); load_all(); run_tile(0, "sat_pos");
    fill_const(-128, 127, -128); load_all(); run_tile(0, "sat_neg");

    // identity keys: S equals Q, exposes key mapping (R2)
    fill(-100, 100);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) km[r][c] = (r == c) ? 1 : 0;
    load_all(); run_tile(0, "R2 identity_key");

    fill_const(0, 0, 0); load_all(); run_tile(0, "zeros");

    fill(-128, 127); load_all();
    run_tile(1, "R2 R8 disturbed");
    run_tile(0, "R2 rerun_no_reload");

    summary();
    $finish;
  end
endmodule